// File: doc/BRIEF.md
# DMA Channel Start Gating and Completion Interrupt Routing

This block sits between the peripherals, the software-visible control state and the channel arbiter of a multi-channel DMA engine. For each channel it decides, every cycle, whether the channel may begin a transfer. A channel is eligible either because its peripheral is asking for service through a single or burst request line, or because software asked for a transfer through a one-cycle software-request write. Peripheral requests can be blocked per channel by a mask, written through separate write-one-to-set and write-one-to-clear ports.

When the data path reports that a channel's transfer has finished, the block raises a completion interrupt. Each channel remembers whether its current transfer was started by software. A software-started transfer reports completion on one shared software interrupt, and every other transfer reports on the channel's own peripheral interrupt. All interrupt flags stay set until written clear. The highest-numbered channel is kept for software use only, and its peripheral request lines are ignored.

Top module: `dma_req_gate`

## Requirements
- R1: After reset the mask is all zero, no software start is pending, no channel is marked software-started, and all interrupt outputs are low.
- R2: A channel other than the reserved one has `start_elig` high in the same cycle whenever all of these hold: it is enabled, it is configured, its mask bit is 0, and `periph_req` or `periph_burst` is high.
- R3: A `mask_set_wr` write sets exactly the mask bits written as 1, from the next cycle on. A set mask bit removes that channel's peripheral request from eligibility.
- R4: A `mask_clr_wr` write clears exactly the mask bits written as 1. If a bit is set and cleared in the same cycle, the set wins.
- R5: A `sw_req_wr` write with bit i at 1, on an enabled channel, makes `start_elig[i]` high for exactly the next cycle, provided the channel is still enabled and configured. This holds whatever the mask and peripheral request are.
- R6: A software-request bit written on a channel that is disabled at the time of the write has no effect. No eligibility pulse follows, and a later completion on that channel is reported as a peripheral completion.
- R7: The reserved channel, index `NUM_CH-1` by default, ignores its peripheral request and burst lines. It becomes eligible only through a software request.
- R8: A `xfer_done[i]` pulse on a channel not marked software-started sets `periph_irq[i]` from the next cycle.
- R9: A channel becomes marked software-started in the cycle its software start is eligible. A `xfer_done[i]` pulse on a marked channel sets `sw_irq` from the next cycle, leaves `periph_irq[i]` unchanged, and removes the mark.
- R10: Interrupt flags stay set until cleared. `irq_clr_wr` clears the `periph_irq` bits written as 1 and leaves the others unchanged, and `sw_irq_clr` clears `sw_irq`.
- R11: When a completion and a clear of the same interrupt flag fall in the same cycle, the flag ends up set.
- R12: When a completion and an eligible software start fall on the same channel in the same cycle, the completion is routed by the mark as it was before that cycle. The new start then marks the channel for its next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | NUM_CH | Per-channel single request from the peripherals |
| periph_burst | input | NUM_CH | Per-channel burst request from the peripherals |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_config | input | NUM_CH | Per-channel "control structure is valid" flag |
| mask_set_wr | input | 1 | Strobe for a write-one-to-set write to the mask |
| mask_set_data | input | NUM_CH | Mask bits to set |
| mask_clr_wr | input | 1 | Strobe for a write-one-to-clear write to the mask |
| mask_clr_data | input | NUM_CH | Mask bits to clear |
| sw_req_wr | input | 1 | Strobe for a software-request write |
| sw_req_data | input | NUM_CH | Channels to start by software |
| xfer_done | input | NUM_CH | One-cycle completion pulse per channel from the data path |
| irq_clr_wr | input | 1 | Strobe for a write-one-to-clear write to the peripheral interrupt flags |
| irq_clr_data | input | NUM_CH | Peripheral interrupt flags to clear |
| sw_irq_clr | input | 1 | Clears the software completion interrupt |
| start_elig | output | NUM_CH | Per-channel start-eligible vector for the arbiter |
| periph_irq | output | NUM_CH | Per-channel peripheral completion interrupt flags |
| sw_irq | output | 1 | Shared software completion interrupt flag |

## Verification
The collisions of interest are a completion arriving on a channel in the very cycle its software start becomes eligible, and a completion arriving in the same cycle as a clear of the interrupt it would set. The bench sets up both on purpose. It issues a software write, then pulses `xfer_done` on the same channel in the pending cycle, and it pulses completions while writing the matching clear bit. A behavioural reference model predicts every cycle which interrupt must end up set and which channel must be eligible, and these predictions are compared against the outputs. A long stretch of random stimulus then lets these collisions and the mask set/clear overlap happen freely.

// File: rtl/dma_gate_pkg.sv
// Package: shared types for the DMA start-gating block.
// Assumes: nothing; it only holds the completion route encoding.
package dma_gate_pkg;

    // Where a channel's completion is reported in a given cycle.
    typedef enum logic [1:0] {
        ROUTE_NONE   = 2'd0,
        ROUTE_PERIPH = 2'd1,
        ROUTE_SW     = 2'd2
    } done_route_t;

endpackage

// File: rtl/dma_mask_reg.sv
// Module: per-channel request mask with separate set and clear write ports.
// Assumes: write strobes are single-cycle pulses from a register decoder;
// when one bit is set and cleared in the same cycle, the set wins.
module dma_mask_reg #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic [NUM_CH-1:0] set_data,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_data,
    output logic [NUM_CH-1:0] mask_q
);

    logic [NUM_CH-1:0] set_bits;
    logic [NUM_CH-1:0] clr_bits;

    // Qualify the write data with its strobe.
    always_comb begin
        set_bits = set_wr ? set_data : '0;
        clr_bits = clr_wr ? clr_data : '0;
    end

    // Hold the mask; clear first, then set so the set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q & ~clr_bits) | set_bits;
        end
    end

endmodule

// File: rtl/dma_swreq_cap.sv
// Module: captures software-request writes as a one-cycle pending pulse.
// Assumes: the channel enable is sampled in the write cycle; a bit written
// for a disabled channel is dropped. Pending bits clear themselves.
module dma_swreq_cap #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [NUM_CH-1:0] sw_data,
    input  logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] sw_pend
);

    logic [NUM_CH-1:0] accepted;

    // Keep only bits of channels enabled at the write.
    always_comb begin
        accepted = sw_wr ? (sw_data & ch_enable) : '0;
    end

    // Register the accepted bits for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend <= '0;
        end else begin
            sw_pend <= accepted;
        end
    end

endmodule

// File: rtl/dma_elig_gate.sv
// Module: combinational start-eligibility per channel.
// Assumes: SW_CH names the software-only channel, whose peripheral lines are
// not wired into eligibility. Software starts bypass the mask.
module dma_elig_gate #(
    parameter int NUM_CH = 8,
    parameter int SW_CH  = NUM_CH - 1
) (
    input  logic [NUM_CH-1:0] periph_req,
    input  logic [NUM_CH-1:0] periph_burst,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_config,
    input  logic [NUM_CH-1:0] mask_q,
    input  logic [NUM_CH-1:0] sw_pend,
    output logic [NUM_CH-1:0] start_elig,
    output logic [NUM_CH-1:0] sw_start
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ready;
        logic hw_want;

        // Channel is usable only when enabled and configured.
        always_comb ready = ch_enable[g] & ch_config[g];

        if (g == SW_CH) begin : g_reserved
            // Reserved channel: peripheral lines never count.
            always_comb hw_want = 1'b0;
        end else begin : g_periph
            // Unmasked single or burst request.
            always_comb hw_want = ~mask_q[g] & (periph_req[g] | periph_burst[g]);
        end

        // Combine the hardware and software paths.
        always_comb begin
            sw_start[g]   = ready & sw_pend[g];
            start_elig[g] = ready & (hw_want | sw_pend[g]);
        end
    end

endmodule

// File: rtl/dma_done_route.sv
// Module: tracks software-started channels and raises completion flags.
// Assumes: xfer_done is a one-cycle pulse; a completion is routed by the
// mark held before the cycle; flag sets win over same-cycle clears.
module dma_done_route
    import dma_gate_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sw_start,
    input  logic [NUM_CH-1:0] xfer_done,
    input  logic              irq_clr_wr,
    input  logic [NUM_CH-1:0] irq_clr_data,
    input  logic              sw_irq_clr,
    output logic [NUM_CH-1:0] sw_origin,
    output logic [NUM_CH-1:0] periph_irq,
    output logic              sw_irq
);

    logic [NUM_CH-1:0] periph_hit;
    logic [NUM_CH-1:0] sw_hit;
    logic [NUM_CH-1:0] clr_bits;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_route
        done_route_t route;

        // Pick the destination of this channel's completion.
        always_comb begin
            if (!xfer_done[g]) begin
                route = ROUTE_NONE;
            end else if (sw_origin[g]) begin
                route = ROUTE_SW;
            end else begin
                route = ROUTE_PERIPH;
            end
            periph_hit[g] = (route == ROUTE_PERIPH);
            sw_hit[g]     = (route == ROUTE_SW);
        end

        // Origin mark: dropped on completion, taken on a software start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_origin[g] <= 1'b0;
            end else if (sw_start[g]) begin
                sw_origin[g] <= 1'b1;
            end else if (xfer_done[g]) begin
                sw_origin[g] <= 1'b0;
            end
        end
    end

    // Qualify the peripheral flag clear with its strobe.
    always_comb clr_bits = irq_clr_wr ? irq_clr_data : '0;

    // Sticky peripheral completion flags, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_irq <= '0;
        end else begin
            periph_irq <= (periph_irq & ~clr_bits) | periph_hit;
        end
    end

    // Sticky shared software completion flag, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_irq <= 1'b0;
        end else if (|sw_hit) begin
            sw_irq <= 1'b1;
        end else if (sw_irq_clr) begin
            sw_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_req_gate.sv
// Module: top of the DMA start-gating and completion-routing block.
// Assumes: register decoding, arbitration and data movement live outside;
// all write strobes and completion pulses last one cycle.
module dma_req_gate #(
    parameter int NUM_CH = 8,
    parameter int SW_CH  = NUM_CH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] periph_req,
    input  logic [NUM_CH-1:0] periph_burst,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_config,
    input  logic              mask_set_wr,
    input  logic [NUM_CH-1:0] mask_set_data,
    input  logic              mask_clr_wr,
    input  logic [NUM_CH-1:0] mask_clr_data,
    input  logic              sw_req_wr,
    input  logic [NUM_CH-1:0] sw_req_data,
    input  logic [NUM_CH-1:0] xfer_done,
    input  logic              irq_clr_wr,
    input  logic [NUM_CH-1:0] irq_clr_data,
    input  logic              sw_irq_clr,
    output logic [NUM_CH-1:0] start_elig,
    output logic [NUM_CH-1:0] periph_irq,
    output logic              sw_irq
);

    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] sw_pend;
    logic [NUM_CH-1:0] sw_start;
    logic [NUM_CH-1:0] sw_origin;

    dma_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr   (mask_set_wr),
        .set_data (mask_set_data),
        .clr_wr   (mask_clr_wr),
        .clr_data (mask_clr_data),
        .mask_q   (mask_q)
    );

    dma_swreq_cap #(.NUM_CH(NUM_CH)) u_swreq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (sw_req_wr),
        .sw_data   (sw_req_data),
        .ch_enable (ch_enable),
        .sw_pend   (sw_pend)
    );

    dma_elig_gate #(.NUM_CH(NUM_CH), .SW_CH(SW_CH)) u_elig (
        .periph_req   (periph_req),
        .periph_burst (periph_burst),
        .ch_enable    (ch_enable),
        .ch_config    (ch_config),
        .mask_q       (mask_q),
        .sw_pend      (sw_pend),
        .start_elig   (start_elig),
        .sw_start     (sw_start)
    );

    dma_done_route #(.NUM_CH(NUM_CH)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_start     (sw_start),
        .xfer_done    (xfer_done),
        .irq_clr_wr   (irq_clr_wr),
        .irq_clr_data (irq_clr_data),
        .sw_irq_clr   (sw_irq_clr),
        .sw_origin    (sw_origin),
        .periph_irq   (periph_irq),
        .sw_irq       (sw_irq)
    );

endmodule

// File: rtl/dma_req_gate_chk.sv
// Module: property checker bound to dma_req_gate.
// Assumes: it observes ports and the mask, pending and origin state.
module dma_req_gate_chk #(
    parameter int NUM_CH = 8,
    parameter int SW_CH  = NUM_CH - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_config,
    input logic              sw_req_wr,
    input logic [NUM_CH-1:0] xfer_done,
    input logic              irq_clr_wr,
    input logic [NUM_CH-1:0] start_elig,
    input logic [NUM_CH-1:0] periph_irq,
    input logic              sw_irq,
    input logic [NUM_CH-1:0] mask_q,
    input logic [NUM_CH-1:0] sw_pend,
    input logic [NUM_CH-1:0] sw_origin
);

    // Eligibility is never granted to a disabled or unconfigured channel.
    assert_elig_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_elig & ~(ch_enable & ch_config)) == '0);

    // A masked channel is eligible only through a pending software start.
    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_elig & mask_q & ~sw_pend) == '0);

    // Without a software write, nothing is pending in the next cycle.
    assert_swpend_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_req_wr |=> (sw_pend == '0));

    // The reserved channel is eligible only by software.
    assert_reserved_sw_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_elig[SW_CH] |-> sw_pend[SW_CH]);

    // A completion on a marked channel raises the software interrupt.
    assert_sw_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_done & sw_origin) != '0) |=> sw_irq);

    // Without a clear write, no peripheral flag drops.
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_clr_wr |=> ((periph_irq & $past(periph_irq)) == $past(periph_irq)));

endmodule

bind dma_req_gate dma_req_gate_chk #(.NUM_CH(NUM_CH), .SW_CH(SW_CH)) u_dma_req_gate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_enable  (ch_enable),
    .ch_config  (ch_config),
    .sw_req_wr  (sw_req_wr),
    .xfer_done  (xfer_done),
    .irq_clr_wr (irq_clr_wr),
    .start_elig (start_elig),
    .periph_irq (periph_irq),
    .sw_irq     (sw_irq),
    .mask_q     (mask_q),
    .sw_pend    (sw_pend),
    .sw_origin  (sw_origin)
);

// File: tb/test_dma_req_gate.sv
`timescale 1ns/1ps
// Bench: cycle-by-cycle comparison against a behavioural reference model.
module test_dma_req_gate;

    localparam int N   = 8;
    localparam int RSV = N - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] periph_req = '0, periph_burst = '0;
    logic [N-1:0] ch_enable = '0, ch_config = '0;
    logic         mask_set_wr = 1'b0, mask_clr_wr = 1'b0, sw_req_wr = 1'b0;
    logic [N-1:0] mask_set_data = '0, mask_clr_data = '0, sw_req_data = '0;
    logic [N-1:0] xfer_done = '0;
    logic         irq_clr_wr = 1'b0, sw_irq_clr = 1'b0;
    logic [N-1:0] irq_clr_data = '0;
    logic [N-1:0] start_elig, periph_irq;
    logic         sw_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state.
    bit m_mask[N];
    bit m_pend[N];
    bit m_org[N];
    bit m_pirq[N];
    bit m_sirq;

    always #2.5 clk = ~clk;

    dma_req_gate #(.NUM_CH(N)) i_dma_req_gate (
        .clk(clk), .rst_n(rst_n),
        .periph_req(periph_req), .periph_burst(periph_burst),
        .ch_enable(ch_enable), .ch_config(ch_config),
        .mask_set_wr(mask_set_wr), .mask_set_data(mask_set_data),
        .mask_clr_wr(mask_clr_wr), .mask_clr_data(mask_clr_data),
        .sw_req_wr(sw_req_wr), .sw_req_data(sw_req_data),
        .xfer_done(xfer_done),
        .irq_clr_wr(irq_clr_wr), .irq_clr_data(irq_clr_data),
        .sw_irq_clr(sw_irq_clr),
        .start_elig(start_elig), .periph_irq(periph_irq), .sw_irq(sw_irq)
    );

    function automatic logic [N-1:0] exp_elig();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) begin
            bit hw;
            hw = (i != RSV) && !m_mask[i] && (periph_req[i] || periph_burst[i]);
            e[i] = ch_enable[i] && ch_config[i] && (hw || m_pend[i]);
        end
        return e;
    endfunction

    function automatic logic [N-1:0] exp_pirq();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_pirq[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_mask[i] = 0; m_pend[i] = 0; m_org[i] = 0; m_pirq[i] = 0;
        end
        m_sirq = 0;
    endtask

    // Advance the model by one clock using the inputs present at the edge.
    task automatic model_tick();
        bit nsirq;
        nsirq = m_sirq;
        if (sw_irq_clr) nsirq = 0;
        for (int i = 0; i < N; i++) begin
            bit start_now;
            start_now = m_pend[i] && ch_enable[i] && ch_config[i];
            if (irq_clr_wr && irq_clr_data[i]) m_pirq[i] = 0;
            if (xfer_done[i]) begin
                if (m_org[i]) nsirq = 1;
                else m_pirq[i] = 1;
            end
            if (start_now) m_org[i] = 1;
            else if (xfer_done[i]) m_org[i] = 0;
            m_pend[i] = sw_req_wr && sw_req_data[i] && ch_enable[i];
            if (mask_clr_wr && mask_clr_data[i]) m_mask[i] = 0;
            if (mask_set_wr && mask_set_data[i]) m_mask[i] = 1;
        end
        m_sirq = nsirq;
    endtask

    task automatic check(string tag);
        logic [N-1:0] ee, ep;
        ee = exp_elig();
        ep = exp_pirq();
        n_cmp++;
        if (start_elig !== ee) begin
            n_bad++;
            $display("FAIL %s start_elig actual=%h expected=%h", tag, start_elig, ee);
        end
        n_cmp++;
        if (periph_irq !== ep) begin
            n_bad++;
            $display("FAIL %s periph_irq actual=%h expected=%h", tag, periph_irq, ep);
        end
        n_cmp++;
        if (sw_irq !== m_sirq) begin
            n_bad++;
            $display("FAIL %s sw_irq actual=%b expected=%b", tag, sw_irq, m_sirq);
        end
    endtask

    // One cycle: compare, take the edge, clear the strobes.
    task automatic step(string tag);
        #1;
        check(tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        mask_set_wr = 0; mask_clr_wr = 0; sw_req_wr = 0;
        irq_clr_wr = 0; sw_irq_clr = 0; xfer_done = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        step("R1");

        ch_enable = '1; ch_config = '1;
        // R2: peripheral eligibility.
        periph_req = 8'h05; step("R2");
        periph_burst = 8'h30; step("R2");
        ch_config[0] = 0; step("R2");
        ch_enable[2] = 0; step("R2");
        ch_config = '1; ch_enable = '1;

        // R3: mask set.
        mask_set_wr = 1; mask_set_data = 8'h0F; step("R3");
        periph_req = 8'hFF; step("R3");
        // R4: clear with same-cycle set on bit 1.
        mask_clr_wr = 1; mask_clr_data = 8'h03; mask_set_wr = 1; mask_set_data = 8'h02; step("R4");
        step("R4");
        mask_clr_wr = 1; mask_clr_data = 8'hFF; step("R4");
        step("R4");

        // R7: reserved channel ignores peripheral lines.
        periph_req = 8'h80; periph_burst = 8'h80; step("R7");

        // R5: software start bypasses mask and request.
        mask_set_wr = 1; mask_set_data = 8'hFF; step("R5");
        periph_req = 8'hFF; sw_req_wr = 1; sw_req_data = 8'h81; step("R5");
        step("R5");
        step("R5");
        periph_req = '0; periph_burst = '0;
        mask_clr_wr = 1; mask_clr_data = 8'hFF; step("R5");
        xfer_done = 8'h81; step("R9");
        step("R9");
        sw_irq_clr = 1; irq_clr_wr = 1; irq_clr_data = 8'hFF; step("R10");

        // R6: software bit on a disabled channel is dropped.
        ch_enable[1] = 0; sw_req_wr = 1; sw_req_data = 8'h02; step("R6");
        ch_enable[1] = 1; step("R6");
        step("R6");
        xfer_done = 8'h02; step("R6");
        step("R6");

        // R8: plain completion.
        xfer_done = 8'h01; step("R8");
        step("R8");

        // R9: software-started completion and mark removal.
        sw_req_wr = 1; sw_req_data = 8'h04; step("R9");
        step("R9");
        xfer_done = 8'h04; step("R9");
        step("R9");
        xfer_done = 8'h04; step("R9");
        step("R9");

        // R10: selective clears.
        irq_clr_wr = 1; irq_clr_data = 8'h01; step("R10");
        step("R10");
        sw_irq_clr = 1; step("R10");
        step("R10");

        // R11: completion against clear in the same cycle.
        xfer_done = 8'h08; irq_clr_wr = 1; irq_clr_data = 8'h08; step("R11");
        step("R11");
        sw_req_wr = 1; sw_req_data = 8'h10; step("R11");
        step("R11");
        xfer_done = 8'h10; sw_irq_clr = 1; step("R11");
        step("R11");
        sw_irq_clr = 1; irq_clr_wr = 1; irq_clr_data = 8'hFF; step("R11");

        // R12: software start eligible in the cycle of a completion.
        sw_req_wr = 1; sw_req_data = 8'h40; step("R12");
        xfer_done = 8'h40; step("R12");
        step("R12");
        xfer_done = 8'h40; step("R12");
        step("R12");

        // Random mix of all inputs; R2 to R12 overlap freely.
        for (int k = 0; k < 2000; k++) begin
            periph_req    = N'($urandom);
            periph_burst  = N'($urandom) & N'($urandom);
            ch_enable     = N'($urandom) | N'($urandom);
            ch_config     = N'($urandom) | N'($urandom);
            mask_set_wr   = ($urandom % 4) == 0; mask_set_data = N'($urandom);
            mask_clr_wr   = ($urandom % 4) == 0; mask_clr_data = N'($urandom);
            sw_req_wr     = ($urandom % 3) == 0; sw_req_data   = N'($urandom);
            xfer_done     = N'($urandom) & N'($urandom);
            irq_clr_wr    = ($urandom % 3) == 0; irq_clr_data  = N'($urandom);
            sw_irq_clr    = ($urandom % 4) == 0;
            step("R12");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule